// File: doc/BRIEF.md
# Staged Pipeline Control Unit

This block is the control section of a five-stage load/store integer pipeline with fetch, decode, execute, memory and write-back stages. The instruction word in the decode stage is decoded once into nine control lines. These lines fall into three groups: execute, memory and write-back. All three groups enter the decode/execute pipeline register together. The execute stage uses its own group and hands the other two onward. The memory stage uses its group and hands only the write-back group to the last register. The control word therefore narrows as it moves down the pipe.

The execute stage also gets a 4-bit ALU function code. It is built from a 2-bit ALU mode and from the low six bits of the sign-extended immediate, which are held in the decode/execute register. The memory stage produces the next-PC select. That select is high only for a branch-equal instruction whose ALU result was zero. The PC and all pipeline registers load on every clock. Fetch and decode carry no instruction-dependent control. A synchronous reset clears every control field, so the pipeline restarts as if it held only no-operations. Hazard detection, forwarding and stalls belong to other blocks.

Top module: `pctl_top`

## Requirements
- R1: Opcode `000000` (instruction bits [31:26]) decodes to: destination-from-rd=1, ALU mode=`10`, register-file write=1, and all other lines 0.
- R2: Opcode `100011` (load) decodes to: ALU-B-from-immediate=1, memory read=1, write-back-selects-load-data=1, register-file write=1, and all other lines 0.
- R3: Opcode `101011` (store) decodes to: ALU-B-from-immediate=1, memory write=1, and all other lines 0.
- R4: Opcode `000100` (branch-equal) decodes to: branch=1, ALU mode=`01`, and all other lines 0.
- R5: Any other opcode drives all nine control lines to 0.
- R6: An instruction presented at decode before clock edge k shows its execute group after edge k, its memory group after edge k+1 and its write-back group after edge k+2.
- R7: The ALU function output is `0010` (add) for mode `00` and `0110` (subtract) for mode `01`, whatever the immediate bits.
- R8: In mode `10` the function code is the low 6 bits of the sign-extended 16-bit immediate (instruction bits [5:0]). It maps as follows: `100000`→`0010`, `100010`→`0110`, `100100`→`0000`, `100101`→`0001`, `101010`→`0111`, and any other code→`1111`.
- R9: The next-PC select is 1 only when the memory-stage branch line is 1 and the ALU zero flag, sampled while that instruction was in execute, was 1.
- R10: The pipeline registers have no enable. A different instruction presented on every cycle is seen in every stage on consecutive cycles, and none is held or skipped.
- R11: While reset is high at a clock edge, every control field of every pipeline register is cleared at that edge. All nine stage outputs and the next-PC select then read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| id_instr | input | 32 | Instruction word in the decode stage |
| ex_alu_zero | input | 1 | ALU zero flag from the execute stage |
| ex_dest_rd | output | 1 | Execute: write destination comes from the rd field |
| ex_alu_mode | output | 2 | Execute: ALU mode (00 add, 01 subtract, 10 function code) |
| ex_b_imm | output | 1 | Execute: ALU B operand is the sign-extended immediate |
| ex_alu_fn | output | 4 | Execute: decoded ALU function |
| mem_is_beq | output | 1 | Memory: branch-equal in this stage |
| mem_ld_en | output | 1 | Memory: data memory read |
| mem_st_en | output | 1 | Memory: data memory write |
| mem_take_tgt | output | 1 | Memory: next PC is the branch target |
| wb_sel_load | output | 1 | Write-back: select load data over the ALU result |
| wb_rf_we | output | 1 | Write-back: register-file write |

## Verification
The bench builds the block with the default parameters: a 32-bit word, a 6-bit opcode, a 16-bit immediate, a 6-bit function code, and the zero flag registered into the execute/memory register (ZERO_IN_MEM=0). These values bring the fixed opcode and function-code encodings into reach, together with the one-cycle offset between the zero flag and the branch line. A new instruction is issued on every cycle, so the three stages are checked against three different table rows at once. One row puts a set sign bit in the immediate, and the load row places a subtract code in its immediate low bits. These rows show that the function code is taken only in mode `10` and that sign extension leaves it unchanged.

// File: rtl/pctl_pkg.sv
package pctl_pkg;

   localparam int CTL_OPC_W  = 6;
   localparam int CTL_MODE_W = 2;
   localparam int CTL_FN_W   = 4;
   localparam int CTL_FUNC_W = 6;

   // Execute-stage group
   typedef struct packed {
      logic                  dest_rd;
      logic [CTL_MODE_W-1:0] alu_mode;
      logic                  b_imm;
   } ex_grp_t;

   // Memory-stage group
   typedef struct packed {
      logic is_beq;
      logic ld_en;
      logic st_en;
   } mem_grp_t;

   // Write-back group
   typedef struct packed {
      logic sel_load;
      logic rf_we;
   } wb_grp_t;

   typedef struct packed {
      mem_grp_t mem;
      wb_grp_t  wb;
   } late_grp_t;

   typedef struct packed {
      ex_grp_t   ex;
      late_grp_t late;
   } ctl_all_t;

   localparam int CTL_ALL_W  = $bits(ctl_all_t);
   localparam int CTL_LATE_W = $bits(late_grp_t);
   localparam int CTL_WB_W   = $bits(wb_grp_t);

   // Opcodes
   localparam logic [CTL_OPC_W-1:0] OPC_REG   = 6'b000000;
   localparam logic [CTL_OPC_W-1:0] OPC_LOAD  = 6'b100011;
   localparam logic [CTL_OPC_W-1:0] OPC_STORE = 6'b101011;
   localparam logic [CTL_OPC_W-1:0] OPC_BEQ   = 6'b000100;

   // ALU modes
   localparam logic [CTL_MODE_W-1:0] MODE_ADD  = 2'b00;
   localparam logic [CTL_MODE_W-1:0] MODE_SUB  = 2'b01;
   localparam logic [CTL_MODE_W-1:0] MODE_FUNC = 2'b10;

   // Function codes
   localparam logic [CTL_FUNC_W-1:0] FC_ADD = 6'b100000;
   localparam logic [CTL_FUNC_W-1:0] FC_SUB = 6'b100010;
   localparam logic [CTL_FUNC_W-1:0] FC_AND = 6'b100100;
   localparam logic [CTL_FUNC_W-1:0] FC_OR  = 6'b100101;
   localparam logic [CTL_FUNC_W-1:0] FC_SLT = 6'b101010;

   // ALU function outputs
   localparam logic [CTL_FN_W-1:0] FN_AND = 4'b0000;
   localparam logic [CTL_FN_W-1:0] FN_OR  = 4'b0001;
   localparam logic [CTL_FN_W-1:0] FN_ADD = 4'b0010;
   localparam logic [CTL_FN_W-1:0] FN_SUB = 4'b0110;
   localparam logic [CTL_FN_W-1:0] FN_SLT = 4'b0111;
   localparam logic [CTL_FN_W-1:0] FN_BAD = 4'b1111;

endpackage

// File: rtl/pctl_decode.sv
module pctl_decode
   import pctl_pkg::*;
#(
   parameter int INSTR_W = 32,
   parameter int OPC_W   = 6,
   parameter int IMM_W   = 16,
   parameter int FUNC_W  = 6
) (
   input  logic [INSTR_W-1:0] instr,
   output ctl_all_t           ctl,
   output logic [FUNC_W-1:0]  func_bits
);

   localparam int SX_W = INSTR_W - IMM_W;

   logic [OPC_W-1:0]   opc;
   logic [INSTR_W-1:0] imm_sx;
   logic               unused_mid;

   assign opc    = instr[INSTR_W-1 -: OPC_W];
   assign imm_sx = {{SX_W{instr[IMM_W-1]}}, instr[IMM_W-1:0]};

   // Low bits of the sign-extended immediate feed ALU control.
   assign func_bits = imm_sx[FUNC_W-1:0];

   // Register fields between the opcode and immediate carry no control.
   assign unused_mid = ^{instr[INSTR_W-OPC_W-1:IMM_W], imm_sx[INSTR_W-1:FUNC_W]};

   always_comb begin
      ctl = '0;
      case (opc)
         OPC_REG: begin
            ctl.ex.dest_rd    = 1'b1;
            ctl.ex.alu_mode   = MODE_FUNC;
            ctl.late.wb.rf_we = 1'b1;
         end
         OPC_LOAD: begin
            ctl.ex.b_imm         = 1'b1;
            ctl.late.mem.ld_en   = 1'b1;
            ctl.late.wb.sel_load = 1'b1;
            ctl.late.wb.rf_we    = 1'b1;
         end
         OPC_STORE: begin
            ctl.ex.b_imm       = 1'b1;
            ctl.late.mem.st_en = 1'b1;
         end
         OPC_BEQ: begin
            ctl.late.mem.is_beq = 1'b1;
            ctl.ex.alu_mode     = MODE_SUB;
         end
         default: ctl = '0;
      endcase
   end

endmodule

// File: rtl/pctl_alu_ctl.sv
module pctl_alu_ctl
   import pctl_pkg::*;
#(
   parameter int MODE_W = 2,
   parameter int FUNC_W = 6,
   parameter int FN_W   = 4
) (
   input  logic [MODE_W-1:0] mode,
   input  logic [FUNC_W-1:0] func_bits,
   output logic [FN_W-1:0]   fn
);

   logic [FN_W-1:0] fn_from_code;

   always_comb begin
      case (func_bits)
         FC_ADD:  fn_from_code = FN_ADD;
         FC_SUB:  fn_from_code = FN_SUB;
         FC_AND:  fn_from_code = FN_AND;
         FC_OR:   fn_from_code = FN_OR;
         FC_SLT:  fn_from_code = FN_SLT;
         default: fn_from_code = FN_BAD;
      endcase
   end

   always_comb begin
      case (mode)
         MODE_ADD:  fn = FN_ADD;
         MODE_SUB:  fn = FN_SUB;
         MODE_FUNC: fn = fn_from_code;
         default:   fn = FN_BAD;
      endcase
   end

endmodule

// File: rtl/pctl_pipe_reg.sv
module pctl_pipe_reg #(
   parameter int CTL_W   = 9,
   parameter int DAT_W   = 1,
   parameter bit HAS_DAT = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CTL_W-1:0] ctl_d,
   output logic [CTL_W-1:0] ctl_q,
   input  logic [DAT_W-1:0] dat_d,
   output logic [DAT_W-1:0] dat_q
);

   if (CTL_W < 1) begin : g_bad_ctl
      $error("pctl_pipe_reg: CTL_W must be at least 1");
   end
   if (DAT_W < 1) begin : g_bad_dat
      $error("pctl_pipe_reg: DAT_W must be at least 1");
   end

   // Control fields: cleared by reset, loaded on every edge.
   always_ff @(posedge clk) begin
      if (rst) ctl_q <= '0;
      else     ctl_q <= ctl_d;
   end

   if (HAS_DAT) begin : g_dat
      // Datapath fields: loaded on every edge and never reset.
      always_ff @(posedge clk) begin
         dat_q <= dat_d;
      end
   end else begin : g_no_dat
      logic unused_dat;
      assign unused_dat = ^dat_d;
      assign dat_q      = '0;
   end

   // R11: a reset edge leaves every control field clear
   p_clear_on_reset_r11: assert property (@(posedge clk) rst |=> (ctl_q == '0))
      else $error("control field not cleared by reset");

endmodule

// File: rtl/pctl_top.sv
module pctl_top
   import pctl_pkg::*;
#(
   parameter int INSTR_W     = 32,
   parameter int OPC_W       = 6,
   parameter int IMM_W       = 16,
   parameter int FUNC_W      = 6,
   parameter int FN_W        = 4,
   parameter bit ZERO_IN_MEM = 1'b0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [INSTR_W-1:0] id_instr,
   input  logic               ex_alu_zero,
   output logic               ex_dest_rd,
   output logic [1:0]         ex_alu_mode,
   output logic               ex_b_imm,
   output logic [FN_W-1:0]    ex_alu_fn,
   output logic               mem_is_beq,
   output logic               mem_ld_en,
   output logic               mem_st_en,
   output logic               mem_take_tgt,
   output logic               wb_sel_load,
   output logic               wb_rf_we
);

   // Elaboration checks
   if (OPC_W != CTL_OPC_W) begin : g_chk_opc
      $error("pctl_top: opcode width must match the encoding");
   end
   if (FUNC_W != CTL_FUNC_W) begin : g_chk_func
      $error("pctl_top: function-code width must match the encoding");
   end
   if (FN_W != CTL_FN_W) begin : g_chk_fn
      $error("pctl_top: ALU function width must be 4");
   end
   if (FUNC_W > IMM_W) begin : g_chk_imm
      $error("pctl_top: function code must fit in the immediate");
   end
   if (IMM_W + OPC_W > INSTR_W) begin : g_chk_word
      $error("pctl_top: opcode and immediate overlap");
   end

   // Decode stage
   ctl_all_t          id_ctl;
   logic [FUNC_W-1:0] id_func;

   pctl_decode #(
      .INSTR_W (INSTR_W),
      .OPC_W   (OPC_W),
      .IMM_W   (IMM_W),
      .FUNC_W  (FUNC_W)
   ) u_decode (
      .instr     (id_instr),
      .ctl       (id_ctl),
      .func_bits (id_func)
   );

   // ID/EX: all three groups plus the function code
   logic [CTL_ALL_W-1:0] idex_ctl_q;
   logic [FUNC_W-1:0]    idex_func_q;
   ctl_all_t             idex_c;

   pctl_pipe_reg #(
      .CTL_W   (CTL_ALL_W),
      .DAT_W   (FUNC_W),
      .HAS_DAT (1'b1)
   ) u_idex (
      .clk   (clk),
      .rst   (rst),
      .ctl_d (id_ctl),
      .ctl_q (idex_ctl_q),
      .dat_d (id_func),
      .dat_q (idex_func_q)
   );

   assign idex_c = ctl_all_t'(idex_ctl_q);

   // Execute stage consumes its group
   assign ex_dest_rd  = idex_c.ex.dest_rd;
   assign ex_alu_mode = idex_c.ex.alu_mode;
   assign ex_b_imm    = idex_c.ex.b_imm;

   pctl_alu_ctl #(
      .MODE_W (CTL_MODE_W),
      .FUNC_W (FUNC_W),
      .FN_W   (FN_W)
   ) u_alu_ctl (
      .mode      (idex_c.ex.alu_mode),
      .func_bits (idex_func_q),
      .fn        (ex_alu_fn)
   );

   // EX/MEM: memory and write-back groups, plus zero flag when registered
   logic [CTL_LATE_W-1:0] exmem_ctl_q;
   logic [0:0]            exmem_zero_q;
   late_grp_t             exmem_c;
   logic                  mem_zero;

   pctl_pipe_reg #(
      .CTL_W   (CTL_LATE_W),
      .DAT_W   (1),
      .HAS_DAT (!ZERO_IN_MEM)
   ) u_exmem (
      .clk   (clk),
      .rst   (rst),
      .ctl_d (idex_c.late),
      .ctl_q (exmem_ctl_q),
      .dat_d (ex_alu_zero),
      .dat_q (exmem_zero_q)
   );

   assign exmem_c = late_grp_t'(exmem_ctl_q);

   if (ZERO_IN_MEM) begin : g_zero_direct
      // Zero flag is already aligned to the memory stage by its source.
      logic unused_zero_q;
      assign unused_zero_q = exmem_zero_q[0];
      assign mem_zero      = ex_alu_zero;
   end else begin : g_zero_reg
      assign mem_zero = exmem_zero_q[0];
   end

   // Memory stage consumes its group
   assign mem_is_beq   = exmem_c.mem.is_beq;
   assign mem_ld_en    = exmem_c.mem.ld_en;
   assign mem_st_en    = exmem_c.mem.st_en;
   assign mem_take_tgt = exmem_c.mem.is_beq & mem_zero;

   // MEM/WB: write-back group only
   logic [CTL_WB_W-1:0] memwb_ctl_q;
   logic [0:0]          memwb_dat_q;
   wb_grp_t             memwb_c;
   logic                unused_memwb;

   pctl_pipe_reg #(
      .CTL_W   (CTL_WB_W),
      .DAT_W   (1),
      .HAS_DAT (1'b0)
   ) u_memwb (
      .clk   (clk),
      .rst   (rst),
      .ctl_d (exmem_c.wb),
      .ctl_q (memwb_ctl_q),
      .dat_d (1'b0),
      .dat_q (memwb_dat_q)
   );

   assign memwb_c      = wb_grp_t'(memwb_ctl_q);
   assign unused_memwb = memwb_dat_q[0];
   assign wb_sel_load  = memwb_c.sel_load;
   assign wb_rf_we     = memwb_c.rf_we;

   // R6: memory outputs follow the execute-stage copy one edge later
   p_mem_follows_ex_r6: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> ({mem_is_beq, mem_ld_en, mem_st_en} == $past(idex_c.late.mem)))
      else $error("memory group did not advance from execute");

   // R6: write-back outputs follow the memory-stage copy one edge later
   p_wb_follows_mem_r6: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> ({wb_sel_load, wb_rf_we} == $past(exmem_c.wb)))
      else $error("write-back group did not advance from memory");

   // R9: branch target only taken with a branch in the memory stage
   p_take_needs_beq_r9: assert property (@(posedge clk) disable iff (rst)
      mem_take_tgt |-> mem_is_beq)
      else $error("branch target selected without a branch");

   // R2: read and write never together in the memory stage
   p_ld_st_excl_r2: assert property (@(posedge clk) disable iff (rst)
      !(mem_ld_en && mem_st_en))
      else $error("memory read and write both active");

   // R2: load-data select only comes with a register write
   p_load_writes_r2: assert property (@(posedge clk) disable iff (rst)
      wb_sel_load |-> wb_rf_we)
      else $error("load data selected without register write");

   // R7: mode 11 is never produced
   p_mode_legal_r7: assert property (@(posedge clk) disable iff (rst)
      ex_alu_mode != 2'b11)
      else $error("illegal ALU mode in execute");

endmodule

// File: tb/pctl_top_tb_top.sv
module pctl_top_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] id_instr = 32'hFC00_0000;
   logic        ex_alu_zero = 1'b0;
   logic        ex_dest_rd;
   logic [1:0]  ex_alu_mode;
   logic        ex_b_imm;
   logic [3:0]  ex_alu_fn;
   logic        mem_is_beq, mem_ld_en, mem_st_en, mem_take_tgt;
   logic        wb_sel_load, wb_rf_we;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;   // 200 MHz

   pctl_top dut_i (
      .clk          (clk),
      .rst          (rst),
      .id_instr     (id_instr),
      .ex_alu_zero  (ex_alu_zero),
      .ex_dest_rd   (ex_dest_rd),
      .ex_alu_mode  (ex_alu_mode),
      .ex_b_imm     (ex_b_imm),
      .ex_alu_fn    (ex_alu_fn),
      .mem_is_beq   (mem_is_beq),
      .mem_ld_en    (mem_ld_en),
      .mem_st_en    (mem_st_en),
      .mem_take_tgt (mem_take_tgt),
      .wb_sel_load  (wb_sel_load),
      .wb_rf_we     (wb_rf_we)
   );

   // ctl bit order: {dest_rd, mode[1:0], b_imm, beq, ld, st, sel_load, rf_we}
   typedef struct packed {
      logic [31:0] ins;
      logic        z;
      logic [8:0]  ctl;
      logic [3:0]  fn;
      logic        pc;
      int          rq;    // requirement number for the decode check
      int          rqa;   // requirement number for the ALU-function check
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VEC [NV] = '{
      '{32'h0000_0020, 1'b0, 9'b1_10_0_000_01, 4'b0010, 1'b0, 1, 8},  // R1 / R8 add
      '{32'h0000_0022, 1'b1, 9'b1_10_0_000_01, 4'b0110, 1'b0, 1, 8},  // R1 / R8 sub, zero ignored R9
      '{32'h0000_0024, 1'b0, 9'b1_10_0_000_01, 4'b0000, 1'b0, 1, 8},  // R8 and
      '{32'h0000_0025, 1'b0, 9'b1_10_0_000_01, 4'b0001, 1'b0, 1, 8},  // R8 or
      '{32'h0000_802A, 1'b0, 9'b1_10_0_000_01, 4'b0111, 1'b0, 1, 8},  // R8 slt, imm sign bit set
      '{32'h0000_003F, 1'b0, 9'b1_10_0_000_01, 4'b1111, 1'b0, 1, 8},  // R8 unknown code
      '{32'h8C00_FFE2, 1'b0, 9'b0_00_1_010_11, 4'b0010, 1'b0, 2, 7},  // R2 load, R7 add despite code
      '{32'hAC00_0008, 1'b1, 9'b0_00_1_001_00, 4'b0010, 1'b0, 3, 7},  // R3 store
      '{32'h1000_0003, 1'b1, 9'b0_01_0_100_00, 4'b0110, 1'b1, 4, 7},  // R4 beq taken R9
      '{32'h1000_0003, 1'b0, 9'b0_01_0_100_00, 4'b0110, 1'b0, 4, 7},  // R4 beq not taken R9
      '{32'h2000_0020, 1'b1, 9'b0_00_0_000_00, 4'b0010, 1'b0, 5, 7},  // R5 other opcode
      '{32'hFC00_002A, 1'b0, 9'b0_00_0_000_00, 4'b0010, 1'b0, 5, 7}   // R5 other opcode
   };

   localparam vec_t NOP = '{32'hFC00_0000, 1'b0, 9'b0, 4'b0010, 1'b0, 5, 7};

   function automatic vec_t row(input int i);
      if (i < 0 || i >= NV) return NOP;
      return VEC[i];
   endfunction

   task automatic chk(input string what, input int rq, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d %s: actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic chk_all_zero(input string what);
      chk({what, " ex"},  11, {ex_dest_rd, ex_alu_mode, ex_b_imm}, 0);
      chk({what, " mem"}, 11, {mem_is_beq, mem_ld_en, mem_st_en, mem_take_tgt}, 0);
      chk({what, " wb"},  11, {wb_sel_load, wb_rf_we}, 0);
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (all requirements): actual=hung expected=done");
      finish_run();
   end

   initial begin
      // R11: reset with a load held at decode leaves every stage clear
      id_instr = 32'h8C00_0004;
      repeat (3) @(posedge clk);
      #1;
      chk_all_zero("reset state");
      chk("reset next-pc", 11, mem_take_tgt, 0);
      rst      = 1'b0;
      id_instr = NOP.ins;
      @(posedge clk);
      #1;

      // R6 / R10: a new row every cycle; stages checked against rows i, i-1, i-2
      for (int i = 0; i < NV + 2; i++) begin
         vec_t e0, e1, e2;
         e0 = row(i);
         e1 = row(i - 1);
         e2 = row(i - 2);
         id_instr    = e0.ins;
         ex_alu_zero = e1.z;   // flag for the instruction now in execute
         @(posedge clk);
         #1;
         chk($sformatf("row %0d ex group", i), e0.rq,
             {ex_dest_rd, ex_alu_mode, ex_b_imm}, e0.ctl[8:5]);
         if (i < NV)
            chk($sformatf("row %0d alu fn", i), e0.rqa, ex_alu_fn, e0.fn);
         chk($sformatf("row %0d mem group R6", i - 1), 6,
             {mem_is_beq, mem_ld_en, mem_st_en}, e1.ctl[4:2]);
         chk($sformatf("row %0d next-pc", i - 1), 9, mem_take_tgt, e1.pc);
         chk($sformatf("row %0d wb group R10", i - 2), 10,
             {wb_sel_load, wb_rf_we}, e2.ctl[1:0]);
      end

      // R11: reset mid-stream clears a full pipeline in one edge
      id_instr    = VEC[8].ins;   // beq
      ex_alu_zero = 1'b0;
      @(posedge clk); #1;
      id_instr    = VEC[6].ins;   // load
      ex_alu_zero = 1'b1;
      @(posedge clk); #1;
      id_instr    = VEC[0].ins;   // R-type
      ex_alu_zero = 1'b1;
      @(posedge clk); #1;
      chk("pre-reset wb R1", 1, {wb_sel_load, wb_rf_we}, 2'b00);
      chk("pre-reset mem load R2", 2, {mem_is_beq, mem_ld_en, mem_st_en}, 3'b010);
      chk("pre-reset ex R-type R1", 1, {ex_dest_rd, ex_alu_mode, ex_b_imm}, 4'b1100);
      rst = 1'b1;
      @(posedge clk); #1;
      chk_all_zero("mid-stream reset");
      chk("mid-stream reset alu fn R7", 7, ex_alu_fn, 4'b0010);

      // R9: taken branch right after reset release, zero aligned to its execute cycle
      rst         = 1'b0;
      id_instr    = VEC[8].ins;
      ex_alu_zero = 1'b0;
      @(posedge clk); #1;
      id_instr    = NOP.ins;
      ex_alu_zero = 1'b1;
      @(posedge clk); #1;
      chk("post-reset branch taken R9", 9, {mem_is_beq, mem_take_tgt}, 2'b11);
      ex_alu_zero = 1'b1;   // bubble in execute: zero must not take a branch
      @(posedge clk); #1;
      chk("zero with bubble R9", 9, mem_take_tgt, 0);

      finish_run();
   end

endmodule